// File: doc/BRIEF.md
# Pointer Sprite Overlay

This block puts a 32 by 32 pointer image on top of a live stream of display pixels. Each clock the video pipeline presents one screen pixel together with the beam coordinates it belongs to. The block decides whether that coordinate falls under the pointer and, if so, combines the screen pixel with two mask bits read from a small on-chip pattern store. The combined pixel leaves two cycles later. Pixels outside the pointer, or with the pointer switched off, are delayed by the same two cycles and are otherwise untouched.

Software writes the pointer position, the pattern block number and an enable bit through a narrow configuration port. These writes land in shadow copies. They reach the drawing logic only when the timing generator pulses the frame-start strobe, so a move never shows up partway through a frame. Pattern bytes are loaded through a separate byte-wide write port. The store holds several 256-byte pattern blocks, and the block number picks which one is drawn.

Top module: `ptr_overlay`

## Requirements
- R1: After reset `pix_out` is 0 and the active configuration is cleared: position 0, block 0, pointer disabled.
- R2: While the active enable bit is clear, every pixel passes through unchanged, including pixels inside the pointer window. Enable is bit 7 of the control register (register select 5).
- R3: Inside the window, the mask pair (AND bit, XOR bit) selects the output: (0,0) gives all zeros, (0,1) gives the bitwise inverse of the screen pixel, (1,0) gives the screen pixel, and (1,1) gives all ones.
- R4: A pixel is inside the window only when 0 ≤ beam_x − X < 32 and 0 ≤ beam_y − Y < 32. The compare is unsigned and does not wrap, so beam coordinates below the position never hit.
- R5: The position is set through four registers selected by `cfg_addr`: 0 holds X bits 7..0, 1 holds X bits 10..8 in data bits 2..0, 2 holds Y bits 7..0, and 3 holds Y bits 9..8 in data bits 1..0.
- R6: Configuration writes have no visible effect until a clock edge on which `frame_start` is high. On that edge the active copy takes the shadow values held before any write made in the same cycle.
- R7: Register select 4 sets the pattern block number; only its low log2(NUM_BLOCKS) bits are used. Within a block, byte 0..127 is the AND mask and byte 128..255 is the XOR mask. Row r, column c is held in byte r*4 + c/8 of each mask, at bit 7 − (c mod 8).
- R8: The output for a pixel appears exactly two clock edges after that pixel is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| pat_we | input | 1 | Pattern store write strobe |
| pat_addr | input | PAT_AW | Pattern byte address: block number, then byte within block |
| pat_wdata | input | 8 | Pattern byte |
| frame_start | input | 1 | Moves the shadow configuration into the active copy |
| beam_x | input | X_W | Horizontal coordinate of the incoming pixel |
| beam_y | input | Y_W | Vertical coordinate of the incoming pixel |
| pix_in | input | PIX_W | Incoming screen pixel |
| pix_out | output | PIX_W | Pixel after the overlay |

## Verification
The pattern under test gives each cell the code (row + column) mod 4, so neighbouring columns walk through all four mask combinations. Probing them with distinct screen values separates black, inverse, pass-through and white, and shows whether the bit order inside a byte is right. Coordinates one pixel inside and one pixel outside each edge of the window, plus a window placed against the maximum X, catch off-by-one errors and wrap-around in the compare. All other pattern blocks are filled with white, so a wrong block number or a swapped AND/XOR half shows up as a different value. Writes made before and after a frame-start strobe tell the shadow copy apart from the active copy.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
    localparam int CUR_DIM   = 32;
    localparam int CUR_LOG   = 5;
    localparam int BYTE_W    = 8;
    localparam int ROW_BYTES = CUR_DIM / BYTE_W;
    localparam int CTRL_EN_BIT = 7;

    typedef enum logic [2:0] {
        REG_XLO  = 3'd0,
        REG_XHI  = 3'd1,
        REG_YLO  = 3'd2,
        REG_YHI  = 3'd3,
        REG_BASE = 3'd4,
        REG_CTRL = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/ptr_regs.sv
module ptr_regs
    import ptr_pkg::*;
#(
    parameter int X_W   = 11,
    parameter int Y_W   = 10,
    parameter int BLK_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [7:0]       cfg_wdata,
    input  logic             frame_start,
    output logic [X_W-1:0]   pos_x,
    output logic [Y_W-1:0]   pos_y,
    output logic [BLK_W-1:0] blk,
    output logic             en
);
    typedef struct packed {
        logic [X_W-1:0]   x;
        logic [Y_W-1:0]   y;
        logic [BLK_W-1:0] blk;
        logic             en;
    } cfg_t;

    typedef struct packed {
        cfg_t shadow;
        cfg_t active;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (frame_start) begin
            s_d.active = s_q.shadow;
        end
        if (cfg_we) begin
            case (reg_sel_e'(cfg_addr))
                REG_XLO:  s_d.shadow.x[7:0]     = cfg_wdata;
                REG_XHI:  s_d.shadow.x[X_W-1:8] = cfg_wdata[X_W-9:0];
                REG_YLO:  s_d.shadow.y[7:0]     = cfg_wdata;
                REG_YHI:  s_d.shadow.y[Y_W-1:8] = cfg_wdata[Y_W-9:0];
                REG_BASE: s_d.shadow.blk        = cfg_wdata[BLK_W-1:0];
                REG_CTRL: s_d.shadow.en         = cfg_wdata[CTRL_EN_BIT];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pos_x = s_q.active.x;
    assign pos_y = s_q.active.y;
    assign blk   = s_q.active.blk;
    assign en    = s_q.active.en;

    // R6: a frame strobe copies the previous shadow into the active copy
    a_r6_frame_load: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (s_q.active == $past(s_q.shadow)));

    // R6: without a frame strobe the active copy stays put
    a_r6_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(s_q.active));
endmodule

// File: rtl/ptr_pattern_ram.sv
module ptr_pattern_ram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_and,
    input  logic [AW-1:0] raddr_xor,
    output logic [7:0]    rdata_and,
    output logic [7:0]    rdata_xor
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata_and = mem_q[raddr_and];
    assign rdata_xor = mem_q[raddr_xor];
endmodule

// File: rtl/ptr_blend.sv
module ptr_blend #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             and_b,
    input  logic             xor_b,
    input  logic [PIX_W-1:0] pix_in,
    output logic [PIX_W-1:0] pix_out
);
    typedef struct packed {
        logic             hit;
        logic             and_b;
        logic             xor_b;
        logic [PIX_W-1:0] pix;
    } stage_t;

    typedef struct packed {
        stage_t           st;
        logic [PIX_W-1:0] out;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d.st.hit   = hit;
        s_d.st.and_b = and_b;
        s_d.st.xor_b = xor_b;
        s_d.st.pix   = pix_in;
        if (s_q.st.hit) begin
            case ({s_q.st.and_b, s_q.st.xor_b})
                2'b00:   s_d.out = '0;
                2'b01:   s_d.out = ~s_q.st.pix;
                2'b10:   s_d.out = s_q.st.pix;
                default: s_d.out = '1;
            endcase
        end else begin
            s_d.out = s_q.st.pix;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pix_out = s_q.out;

    // R2 / R4: a pixel that missed the pointer leaves unchanged one edge later
    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.st.hit |=> (pix_out == $past(s_q.st.pix)));

    // R3: both masks set yields all ones
    a_r3_white: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st.hit && s_q.st.and_b && s_q.st.xor_b) |=> (pix_out == '1));

    // R3: both masks clear yields all zeros
    a_r3_black: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st.hit && !s_q.st.and_b && !s_q.st.xor_b) |=> (pix_out == '0));

    // R3: XOR alone inverts the screen pixel
    a_r3_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st.hit && !s_q.st.and_b && s_q.st.xor_b) |=> (pix_out == ~$past(s_q.st.pix)));
endmodule

// File: rtl/ptr_overlay.sv
module ptr_overlay
    import ptr_pkg::*;
#(
    parameter int PIX_W      = 8,
    parameter int X_W        = 11,
    parameter int Y_W        = 10,
    parameter int NUM_BLOCKS = 4,
    localparam int BLK_W     = $clog2(NUM_BLOCKS),
    localparam int PAT_AW    = BLK_W + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              pat_we,
    input  logic [PAT_AW-1:0] pat_addr,
    input  logic [7:0]        pat_wdata,
    input  logic              frame_start,
    input  logic [X_W-1:0]    beam_x,
    input  logic [Y_W-1:0]    beam_y,
    input  logic [PIX_W-1:0]  pix_in,
    output logic [PIX_W-1:0]  pix_out
);
    logic [X_W-1:0]   pos_x;
    logic [Y_W-1:0]   pos_y;
    logic [BLK_W-1:0] blk;
    logic             en;

    ptr_regs #(.X_W(X_W), .Y_W(Y_W), .BLK_W(BLK_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .frame_start(frame_start),
        .pos_x(pos_x), .pos_y(pos_y), .blk(blk), .en(en)
    );

    // Window compare: extra top bit of each difference is the borrow
    logic [X_W:0]        dx;
    logic [Y_W:0]        dy;
    logic                in_x, in_y, hit;
    logic [CUR_LOG-1:0]  col, row;

    always_comb begin
        dx   = {1'b0, beam_x} - {1'b0, pos_x};
        dy   = {1'b0, beam_y} - {1'b0, pos_y};
        in_x = !dx[X_W] && (dx[X_W-1:0] < X_W'(CUR_DIM));
        in_y = !dy[Y_W] && (dy[Y_W-1:0] < Y_W'(CUR_DIM));
        hit  = en && in_x && in_y;
        col  = dx[CUR_LOG-1:0];
        row  = dy[CUR_LOG-1:0];
    end

    // Pattern fetch: block, mask half, row, byte within row
    logic [PAT_AW-1:0] addr_and, addr_xor;
    logic [7:0]        byte_and, byte_xor;
    logic [2:0]        bit_sel;
    logic              and_b, xor_b;

    always_comb begin
        addr_and = {blk, 1'b0, row, col[CUR_LOG-1:3]};
        addr_xor = {blk, 1'b1, row, col[CUR_LOG-1:3]};
        bit_sel  = 3'd7 - col[2:0];
    end

    ptr_pattern_ram #(.AW(PAT_AW)) u_ram (
        .clk(clk),
        .we(pat_we), .waddr(pat_addr), .wdata(pat_wdata),
        .raddr_and(addr_and), .raddr_xor(addr_xor),
        .rdata_and(byte_and), .rdata_xor(byte_xor)
    );

    assign and_b = byte_and[bit_sel];
    assign xor_b = byte_xor[bit_sel];

    ptr_blend #(.PIX_W(PIX_W)) u_blend (
        .clk(clk), .rst_n(rst_n),
        .hit(hit), .and_b(and_b), .xor_b(xor_b),
        .pix_in(pix_in), .pix_out(pix_out)
    );

    // R2: with the pointer disabled no pixel is ever a hit
    a_r2_no_hit_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !hit);
endmodule

// File: tb/tb_ptr_overlay.sv
module tb_ptr_overlay;
    localparam int PIX_W = 8;
    localparam int X_W = 11;
    localparam int Y_W = 10;
    localparam int NUM_BLOCKS = 4;
    localparam int PAT_AW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic pat_we = 1'b0;
    logic [PAT_AW-1:0] pat_addr = '0;
    logic [7:0] pat_wdata = '0;
    logic frame_start = 1'b0;
    logic [X_W-1:0] beam_x = '0;
    logic [Y_W-1:0] beam_y = '0;
    logic [PIX_W-1:0] pix_in = '0;
    logic [PIX_W-1:0] pix_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ptr_overlay #(.PIX_W(PIX_W), .X_W(X_W), .Y_W(Y_W), .NUM_BLOCKS(NUM_BLOCKS)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pat_we(pat_we), .pat_addr(pat_addr), .pat_wdata(pat_wdata),
        .frame_start(frame_start),
        .beam_x(beam_x), .beam_y(beam_y), .pix_in(pix_in), .pix_out(pix_out)
    );

    typedef struct packed {
        logic [X_W-1:0]   bx;
        logic [Y_W-1:0]   by;
        logic [PIX_W-1:0] pix;
        logic [PIX_W-1:0] exp;
    } vec_t;

    // Pointer at X=500, Y=300; cell code = (row+col) mod 4 -> {AND,XOR}
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{11'd500, 10'd300, 8'h5A, 8'h00},  // R3 code 0 black
        '{11'd501, 10'd300, 8'h5A, 8'hA5},  // R3 code 1 inverse
        '{11'd502, 10'd300, 8'h5A, 8'h5A},  // R3 code 2 screen
        '{11'd503, 10'd300, 8'h5A, 8'hFF},  // R3 code 3 white
        '{11'd531, 10'd330, 8'h33, 8'hCC},  // R4 far corner area
        '{11'd532, 10'd300, 8'h33, 8'h33},  // R4 right of window
        '{11'd499, 10'd300, 8'h33, 8'h33},  // R4 left of window
        '{11'd500, 10'd332, 8'h77, 8'h77},  // R4 below window
        '{11'd500, 10'd299, 8'h77, 8'h77},  // R4 above window
        '{11'd521, 10'd310, 8'h10, 8'hFF},  // R7 byte 2
        '{11'd512, 10'd301, 8'h10, 8'hEF},  // R7 byte 1 row 1
        '{11'd508, 10'd300, 8'h81, 8'h00}   // R7 byte boundary
    };

    function automatic logic [1:0] cell_code(int r, int c);
        return 2'((r + c) % 4);
    endfunction

    task automatic check(string req, logic [PIX_W-1:0] act, logic [PIX_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: pix_out=%h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic pat_write(int a, logic [7:0] d);
        @(negedge clk);
        pat_we = 1'b1; pat_addr = PAT_AW'(a); pat_wdata = d;
        @(negedge clk);
        pat_we = 1'b0;
    endtask

    // Present one pixel, return output two edges later
    task automatic pixel(int x, int y, logic [7:0] p, output logic [7:0] res);
        @(negedge clk);
        beam_x = X_W'(x); beam_y = Y_W'(y); pix_in = p;
        @(negedge clk);
        @(negedge clk);
        res = pix_out;
    endtask

    task automatic set_pos(int x, int y);
        cfg_write(3'd0, 8'(x & 8'hFF));
        cfg_write(3'd1, 8'(x >> 8));
        cfg_write(3'd2, 8'(y & 8'hFF));
        cfg_write(3'd3, 8'(y >> 8));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [7:0] ab, xb;
        repeat (3) @(negedge clk);
        // R1: output cleared in reset
        check("R1 reset output", pix_out, 8'h00);
        rst_n = 1'b1;
        // R1 / R2: cleared enable -> pass-through at origin
        pixel(0, 0, 8'h3C, r);
        check("R1 disabled after reset", r, 8'h3C);

        // Fill every block with white (all ones in both halves)
        for (int a = 0; a < NUM_BLOCKS * 256; a++) pat_write(a, 8'hFF);
        // Block 2 gets the test pattern
        for (int rr = 0; rr < 32; rr++) begin
            for (int b = 0; b < 4; b++) begin
                for (int k = 0; k < 8; k++) begin
                    logic [1:0] cc;
                    cc = cell_code(rr, b * 8 + k);
                    ab[7 - k] = cc[1];
                    xb[7 - k] = cc[0];
                end
                pat_write(2 * 256 + rr * 4 + b, ab);
                pat_write(2 * 256 + 128 + rr * 4 + b, xb);
            end
        end

        // R5 / R7 / R6: program shadow, base 6 maps to block 2
        set_pos(500, 300);
        cfg_write(3'd4, 8'h06);
        cfg_write(3'd5, 8'h80);
        pixel(500, 300, 8'h5A, r);
        check("R6 shadow not yet active", r, 8'h5A);
        pulse_frame();
        pixel(500, 300, 8'h5A, r);
        check("R6 active after frame", r, 8'h00);

        for (int i = 0; i < NV; i++) begin
            pixel(int'(VECS[i].bx), int'(VECS[i].by), VECS[i].pix, r);
            check($sformatf("R3/R4/R7 vector %0d", i), r, VECS[i].exp);
        end

        // R8: previous output holds after one edge, new value after two
        pixel(503, 300, 8'h11, r);          // white
        @(negedge clk);
        beam_x = 11'd500; beam_y = 10'd300; pix_in = 8'h11;
        @(negedge clk);
        check("R8 one edge later", pix_out, 8'hFF);
        @(negedge clk);
        check("R8 two edges later", pix_out, 8'h00);

        // R6 / R2: disable written but not yet taken
        cfg_write(3'd5, 8'h7F);
        pixel(500, 300, 8'h5A, r);
        check("R6 disable pending", r, 8'h00);
        pulse_frame();
        pixel(500, 300, 8'h5A, r);
        check("R2 disabled inside window", r, 8'h5A);

        // R5 / R4: window against maximum X, Y 0
        set_pos(2040, 0);
        cfg_write(3'd5, 8'h80);
        pulse_frame();
        pixel(2047, 0, 8'h42, r);
        check("R5 high X bits, code 3", r, 8'hFF);
        pixel(2046, 31, 8'h42, r);
        check("R5 row 31 col 6 code 1", r, 8'hBD);
        pixel(0, 0, 8'h42, r);
        check("R4 no wrap past X max", r, 8'h42);
        pixel(2047, 32, 8'h42, r);
        check("R4 below window", r, 8'h42);

        // R7: block 0 is all white
        cfg_write(3'd4, 8'h00);
        pulse_frame();
        pixel(2040, 0, 8'h42, r);
        check("R7 block 0 white", r, 8'hFF);

        // R1: reset clears the active configuration
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", pix_out, 8'h00);
        rst_n = 1'b1;
        pixel(2047, 0, 8'h42, r);
        check("R1 pointer off after reset", r, 8'h42);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule